// File: doc/BRIEF.md
# Chip-Select Decoder with Boot ROM Overlay

This block turns the bus strobes of an 8-bit processor with a 16-bit address bus into active-low chip selects. Memory accesses are decoded from the upper address byte only. The map has three parts: a 56 KiB RAM region at the bottom, eight 512-byte peripheral windows above it, and a 4 KiB ROM region at the top. A separate 256-port I/O space is decoded from the low address byte into eight groups of 32 ports. The address latch, the memory arrays and wait states are handled elsewhere.

Because the processor starts at address zero, a one-bit overlay flag is set by reset. While the flag is set, every memory read is answered by ROM, so the vectors in the first page come from ROM. Writes still reach RAM and the peripheral windows, so boot code can copy itself into low memory. A write to the release port in I/O space clears the flag. The flag stays clear until the next reset, and after that the ROM is seen only in its own top region.

Top module: `chipsel_decoder`

## Requirements
- R1: With the overlay clear, a memory access (read or write) whose upper byte is 0x00–0xDF asserts only `ramSelN`.
- R2: A memory read whose upper byte is 0xF0–0xFF asserts only `romSelN`. A memory write to that range asserts no select, and `romSelN` is never low without an active read strobe.
- R3: With the overlay clear, a memory access whose upper byte is 0xE0–0xEF asserts only `perSelN[k]`, where k is bits 3..1 of the upper byte (address bits 11..9).
- R4: While the overlay is set, every memory read, including those in the vector page 0x0000–0x00FF, asserts `romSelN` and no other select.
- R5: While the overlay is set, memory writes decode as in R1 and R3 (RAM or the peripheral windows) and never select ROM.
- R6: An I/O write to port 0xFF clears the overlay from the next rising clock edge on. I/O reads of 0xFF, I/O writes to other ports, and memory writes do not clear it. Once clear, it stays clear.
- R7: An I/O access (I/O request low, memory request high, read or write low) asserts only `ioSelN[g]`, with g = port bits 7..5.
- R8: With no request strobe active, with neither read nor write active, or with both request strobes active at once, every select is high.
- R9: At most one memory select is low at a time, and memory and I/O selects are never low together.
- R10: Asserting `rstN` low sets the overlay again, whatever its state was before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the overlay flag |
| rstN | input | 1 | Asynchronous active-low reset; sets the overlay |
| addrHi | input | 8 | Upper address byte (A15..A8) |
| ioAddr | input | 8 | Low address byte, used as the I/O port number |
| memReqN | input | 1 | Active-low memory request |
| ioReqN | input | 1 | Active-low I/O request |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| ramSelN | output | 1 | Active-low RAM select |
| romSelN | output | 1 | Active-low ROM select |
| perSelN | output | 8 | Active-low peripheral window selects |
| ioSelN | output | 8 | Active-low I/O port group selects |

## Verification
Every select is a combinational function of the present strobes and the overlay flag, so it is due in the same cycle as its stimulus. The bench drives inputs at the falling edge and compares 5 ns later, well before the next rising edge. The only registered effect is the overlay release, which is due at the rising edge that samples the release write. The reference model clears its own flag just after that edge, so the first comparison that expects the new map is the next access. Reset re-arms the flag at once, and both the model and the following check reflect that immediately.

// File: rtl/chipsel_pkg.sv
package chipsel_pkg;

  // Qualified strobes handed from the overlay control to the region decoder
  typedef struct packed {
    logic memAct;     // memory request alone is active
    logic ioAct;      // I/O request alone is active
    logic rdAct;      // read strobe active
    logic wrAct;      // write strobe active
    logic overlayOn;  // boot overlay: reads go to ROM
  } busStrobe_t;

endpackage

// File: rtl/chipsel_overlay_ctrl.sv
module chipsel_overlay_ctrl
  import chipsel_pkg::*;
#(
  parameter int unsigned IO_W = 8,
  parameter logic [IO_W-1:0] RELEASE_PORT = '1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            memReqN,
  input  logic            ioReqN,
  input  logic            rdN,
  input  logic            wrN,
  input  logic [IO_W-1:0] ioAddr,
  output busStrobe_t      strobes
);

  logic overlayQ;
  logic memAct;
  logic ioAct;
  logic releaseHit;

  // A request counts only when the other space is idle; both at once is ignored
  assign memAct = !memReqN && ioReqN;
  assign ioAct  = !ioReqN && memReqN;

  assign releaseHit = ioAct && !wrN && (ioAddr == RELEASE_PORT);

  // Set by reset, cleared once by the release write, sticky until next reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overlayQ <= 1'b1;
    end else if (releaseHit) begin
      overlayQ <= 1'b0;
    end
  end

  always_comb begin
    strobes.memAct    = memAct;
    strobes.ioAct     = ioAct;
    strobes.rdAct     = !rdN;
    strobes.wrAct     = !wrN;
    strobes.overlayOn = overlayQ;
  end

endmodule

// File: rtl/chipsel_region_dec.sv
module chipsel_region_dec
  import chipsel_pkg::*;
#(
  parameter int unsigned HI_W        = 8,
  parameter int unsigned RAM_END_HI  = 8'hDF,
  parameter int unsigned ROM_BASE_HI = 8'hF0,
  parameter int unsigned NUM_WIN     = 8,
  parameter int unsigned IO_W        = 8,
  parameter int unsigned NUM_IO_GRP  = 8
) (
  input  busStrobe_t            strobes,
  input  logic [HI_W-1:0]       addrHi,
  input  logic [IO_W-1:0]       ioAddr,
  output logic                  ramSelN,
  output logic                  romSelN,
  output logic [NUM_WIN-1:0]    perSelN,
  output logic [NUM_IO_GRP-1:0] ioSelN
);

  localparam int unsigned PER_BASE_HI   = RAM_END_HI + 1;
  localparam int unsigned PAGES_PER_WIN = (ROM_BASE_HI - PER_BASE_HI) / NUM_WIN;
  localparam int unsigned WIN_SHIFT     = $clog2(PAGES_PER_WIN);
  localparam int unsigned GRP_W         = $clog2(NUM_IO_GRP);

  localparam logic [HI_W-1:0] RAM_END  = HI_W'(RAM_END_HI);
  localparam logic [HI_W-1:0] PER_BASE = HI_W'(PER_BASE_HI);
  localparam logic [HI_W-1:0] ROM_BASE = HI_W'(ROM_BASE_HI);

  logic            access;
  logic            readToRom;
  logic            ramHit;
  logic            romHit;
  logic            winHit;
  logic [HI_W-1:0] winOff;
  logic [HI_W-1:0] winIdx;
  logic [GRP_W-1:0] grpIdx;
  logic            memGo;
  logic            ioGo;

  assign access    = strobes.rdAct || strobes.wrAct;
  // While the overlay is on, reads are steered to ROM and masked elsewhere
  assign readToRom = strobes.overlayOn && strobes.rdAct;

  assign ramHit = (addrHi <= RAM_END);
  assign romHit = (addrHi >= ROM_BASE);
  assign winHit = !ramHit && !romHit;

  assign winOff = addrHi - PER_BASE;
  assign winIdx = winOff >> WIN_SHIFT;
  assign grpIdx = ioAddr[IO_W-1 -: GRP_W];

  assign memGo = strobes.memAct && access && !readToRom;
  assign ioGo  = strobes.ioAct && access;

  assign romSelN = !(strobes.memAct && strobes.rdAct && (romHit || strobes.overlayOn));
  assign ramSelN = !(memGo && ramHit);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign perSelN[w] = !(memGo && winHit && (winIdx == HI_W'(w)));
  end

  for (genvar g = 0; g < NUM_IO_GRP; g++) begin : g_iogrp
    assign ioSelN[g] = !(ioGo && (grpIdx == GRP_W'(g)));
  end

endmodule

// File: rtl/chipsel_decoder.sv
module chipsel_decoder
  import chipsel_pkg::*;
#(
  parameter int unsigned HI_W        = 8,
  parameter int unsigned IO_W        = 8,
  parameter int unsigned RAM_END_HI  = 8'hDF,
  parameter int unsigned ROM_BASE_HI = 8'hF0,
  parameter int unsigned NUM_WIN     = 8,
  parameter int unsigned NUM_IO_GRP  = 8,
  parameter logic [IO_W-1:0] RELEASE_PORT = '1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [HI_W-1:0]       addrHi,
  input  logic [IO_W-1:0]       ioAddr,
  input  logic                  memReqN,
  input  logic                  ioReqN,
  input  logic                  rdN,
  input  logic                  wrN,
  output logic                  ramSelN,
  output logic                  romSelN,
  output logic [NUM_WIN-1:0]    perSelN,
  output logic [NUM_IO_GRP-1:0] ioSelN
);

  busStrobe_t strobes;
  logic       overlayOn;

  assign overlayOn = strobes.overlayOn;

  chipsel_overlay_ctrl #(
    .IO_W         (IO_W),
    .RELEASE_PORT (RELEASE_PORT)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .memReqN (memReqN),
    .ioReqN  (ioReqN),
    .rdN     (rdN),
    .wrN     (wrN),
    .ioAddr  (ioAddr),
    .strobes (strobes)
  );

  chipsel_region_dec #(
    .HI_W        (HI_W),
    .RAM_END_HI  (RAM_END_HI),
    .ROM_BASE_HI (ROM_BASE_HI),
    .NUM_WIN     (NUM_WIN),
    .IO_W        (IO_W),
    .NUM_IO_GRP  (NUM_IO_GRP)
  ) u_dec (
    .strobes (strobes),
    .addrHi  (addrHi),
    .ioAddr  (ioAddr),
    .ramSelN (ramSelN),
    .romSelN (romSelN),
    .perSelN (perSelN),
    .ioSelN  (ioSelN)
  );

endmodule

// File: rtl/chipsel_checker.sv
module chipsel_checker #(
  parameter int unsigned IO_W       = 8,
  parameter int unsigned NUM_WIN    = 8,
  parameter int unsigned NUM_IO_GRP = 8,
  parameter logic [IO_W-1:0] RELEASE_PORT = '1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [IO_W-1:0]       ioAddr,
  input logic                  memReqN,
  input logic                  ioReqN,
  input logic                  rdN,
  input logic                  wrN,
  input logic                  ramSelN,
  input logic                  romSelN,
  input logic [NUM_WIN-1:0]    perSelN,
  input logic [NUM_IO_GRP-1:0] ioSelN,
  input logic                  overlayOn
);

  logic [NUM_WIN+1:0]    memSelAct;
  logic [NUM_IO_GRP-1:0] ioSelAct;

  assign memSelAct = ~{ramSelN, romSelN, perSelN};
  assign ioSelAct  = ~ioSelN;

  // R9: one memory select at most
  a_r9_one_mem_sel: assert property (@(posedge clk) disable iff (!rstN)
    $countones(memSelAct) <= 1);

  // R9: memory and I/O selects exclusive
  a_r9_mem_io_excl: assert property (@(posedge clk) disable iff (!rstN)
    !((|memSelAct) && (|ioSelAct)));

  // R8: idle or conflicting strobes leave every select high
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((memReqN && ioReqN) || (rdN && wrN) || (!memReqN && !ioReqN))
      |-> (memSelAct == '0 && ioSelAct == '0));

  // R2: ROM select only on a memory read
  a_r2_rom_read_only: assert property (@(posedge clk) disable iff (!rstN)
    !romSelN |-> (!rdN && !memReqN && ioReqN));

  // R7: I/O selects only under an I/O request
  a_r7_io_needs_ioreq: assert property (@(posedge clk) disable iff (!rstN)
    (|ioSelAct) |-> (!ioReqN && memReqN));

  // R4: overlay steers every memory read to ROM
  a_r4_overlay_rom: assert property (@(posedge clk) disable iff (!rstN)
    (overlayOn && !memReqN && ioReqN && !rdN) |-> (!romSelN && ramSelN && perSelN == '1));

  // R6: release write clears the overlay at the next edge
  a_r6_release: assert property (@(posedge clk) disable iff (!rstN)
    (!ioReqN && memReqN && !wrN && ioAddr == RELEASE_PORT) |=> !overlayOn);

  // R6: once clear, the overlay stays clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !overlayOn |=> !overlayOn);

endmodule

bind chipsel_decoder chipsel_checker #(
  .IO_W         (IO_W),
  .NUM_WIN      (NUM_WIN),
  .NUM_IO_GRP   (NUM_IO_GRP),
  .RELEASE_PORT (RELEASE_PORT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ioAddr    (ioAddr),
  .memReqN   (memReqN),
  .ioReqN    (ioReqN),
  .rdN       (rdN),
  .wrN       (wrN),
  .ramSelN   (ramSelN),
  .romSelN   (romSelN),
  .perSelN   (perSelN),
  .ioSelN    (ioSelN),
  .overlayOn (overlayOn)
);

// File: tb/tb_chipsel_decoder.sv
`timescale 1ns/1ps
module tb_chipsel_decoder;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] addrHi = 8'h00;
  logic [7:0] ioAddr = 8'h00;
  logic       memReqN = 1'b1;
  logic       ioReqN = 1'b1;
  logic       rdN = 1'b1;
  logic       wrN = 1'b1;
  logic       ramSelN;
  logic       romSelN;
  logic [7:0] perSelN;
  logic [7:0] ioSelN;

  int compared = 0;
  int mismatched = 0;
  bit modelOverlay = 1'b1;

  always #10 clk = ~clk;   // 50 MHz

  chipsel_decoder dut (
    .clk(clk), .rstN(rstN), .addrHi(addrHi), .ioAddr(ioAddr),
    .memReqN(memReqN), .ioReqN(ioReqN), .rdN(rdN), .wrN(wrN),
    .ramSelN(ramSelN), .romSelN(romSelN), .perSelN(perSelN), .ioSelN(ioSelN)
  );

  // Behavioural reference: full 16-bit address arithmetic on integers
  function automatic logic [17:0] expectSel();
    logic ramE = 1'b1;
    logic romE = 1'b1;
    logic [7:0] perE = 8'hFF;
    logic [7:0] ioE = 8'hFF;
    int addr = int'(addrHi) * 256;
    bit rd = !rdN;
    bit wr = !wrN;
    bit memOnly = !memReqN && ioReqN;
    bit ioOnly = !ioReqN && memReqN;
    if (memOnly && (rd || wr)) begin
      if (rd && (addr >= 'hF000 || modelOverlay)) romE = 1'b0;
      if (!(rd && modelOverlay)) begin
        if (addr < 'hE000) ramE = 1'b0;
        else if (addr < 'hF000) perE[(addr - 'hE000) / 512] = 1'b0;
      end
    end
    if (ioOnly && (rd || wr)) ioE[int'(ioAddr) / 32] = 1'b0;
    return {ramE, romE, perE, ioE};
  endfunction

  function automatic string regionTag(input int hi);
    if (hi < 'hE0) return "R1";
    if (hi < 'hF0) return "R3";
    return "R2";
  endfunction

  task automatic compareNow(input string tag);
    logic [17:0] got;
    logic [17:0] exp;
    got = {ramSelN, romSelN, perSelN, ioSelN};
    exp = expectSel();
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s hi=%h port=%h mreq=%b ioreq=%b rd=%b wr=%b got=%h exp=%h",
               tag, addrHi, ioAddr, memReqN, ioReqN, rdN, wrN, got, exp);
    end
  endtask

  // Drive at falling edge, compare mid-low-phase, update model after rising edge
  task automatic step(input logic [7:0] hi, input logic [7:0] port,
                      input logic mq, input logic iq, input logic r, input logic w,
                      input string tag);
    @(negedge clk);
    addrHi = hi; ioAddr = port; memReqN = mq; ioReqN = iq; rdN = r; wrN = w;
    #5;
    compareNow(tag);
    @(posedge clk);
    if (rstN && !ioReqN && memReqN && !wrN && ioAddr == 8'hFF) modelOverlay = 1'b0;
  endtask

  task automatic doReset(input string tag);
    @(negedge clk);
    memReqN = 1'b1; ioReqN = 1'b1; rdN = 1'b1; wrN = 1'b1;
    rstN = 1'b0;
    modelOverlay = 1'b1;
    #5;
    compareNow(tag);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // Reset state: everything idle (R8)
    doReset("R8");

    // Overlay set: every read to ROM (R4), writes to RAM/windows (R5)
    for (int hi = 0; hi < 256; hi++) step(8'(hi), 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
    for (int hi = 0; hi < 256; hi++) step(8'(hi), 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, "R5");

    // Vector page: restart vectors 0x00..0x38 and NMI 0x66, all in page 0 (R4)
    for (int v = 0; v <= 'h38; v += 8) step(8'(v >> 8), 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
    step(8'('h66 >> 8), 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, "R4");

    // Actions that must not release the overlay (R6)
    step(8'h00, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b1, "R6");   // I/O read of 0xFF
    step(8'h00, 8'hFE, 1'b1, 1'b0, 1'b1, 1'b0, "R6");   // I/O write elsewhere
    step(8'hFF, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, "R6");   // memory write
    step(8'h00, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, "R8");   // both requests
    step(8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, "R6");   // still ROM

    // Idle / no-strobe cases (R8)
    step(8'h10, 8'h20, 1'b0, 1'b1, 1'b1, 1'b1, "R8");
    step(8'hE4, 8'h40, 1'b1, 1'b1, 1'b0, 1'b1, "R8");
    step(8'hF8, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1, "R8");

    // Release, then low page reads come from RAM (R6)
    step(8'h00, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
    step(8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, "R6");

    // Overlay clear sweep (R1 R2 R3), read then write; R9 also covered
    for (int hi = 0; hi < 256; hi++) step(8'(hi), 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, regionTag(hi));
    for (int hi = 0; hi < 256; hi++) step(8'(hi), 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, regionTag(hi));

    // I/O group sweep (R7)
    for (int p = 0; p < 256; p++) step(8'h00, 8'(p), 1'b1, 1'b0, 1'b0, 1'b1, "R7");
    for (int p = 0; p < 256; p++) step(8'hF0, 8'(p), 1'b1, 1'b0, 1'b1, 1'b0, "R7");

    // Reset re-arms the overlay (R10)
    doReset("R10");
    step(8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, "R10");
    step(8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, "R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule